// File: doc/BRIEF.md
# Fused Compare-and-Branch Unit

This unit resolves a branch instruction that carries its own comparison, so no earlier compare instruction is needed. In one operation it compares a register operand with a second register or a small immediate, produces the four-bit condition field, and decides whether the branch is taken. It also computes the branch target and, when asked, the link address.

The unit has two operation families. The compare family can run a signed or an unsigned comparison and can pick the less-than, greater-than or equal flag as the branch condition. A fourth selector value turns it into a subtract-and-compare step: the difference is written back to the first register, and the branch tests equality of the old value. The bit-test family builds a single-bit mask from a register or from an immediate bit number, counting bit 0 as the MSB. It branches on whether the masked operand is zero. Its clearing variant inverts the mask and writes the masked operand back.

Register indices are checked against a fixed map of implemented registers. An index that is not implemented raises an illegal flag and suppresses every write. All results are registered and appear one cycle after issue. Instruction fetch and pipeline flush are handled elsewhere.

Top module: `fcb_unit`

## Requirements
- R1: A compare writes cr0_o as {LT, GT, EQ, SO}, in bits 3, 2, 1, 0 of the field. Exactly one of LT, GT and EQ is set, from a 32-bit comparison that is signed when signed_i=1 and unsigned otherwise. SO is copied from so_i.
- R2: The branch is taken when the cr0_o bit picked by sel_i equals pol_i, where sel_i 0 picks LT (bit 3), 1 picks GT (bit 2) and 2 picks EQ (bit 1). A taken branch gives next_pc_o = cia_i + sign-extended disp_i. A branch that is not taken gives cia_i + 4.
- R3: In the compare family, sel_i=3 writes ra - rb to register ra_idx_i (ra_we_o=1) and compares the old ra value with rb. The branch then tests EQ.
- R4: With link_i=1, lr_we_o=1 and lr_o = cia_i + 4, whether or not the branch is taken.
- R5: In the bit-test family (bit_test_i=1), the mask is 32'h8000_0000 shifted right by rb_val_i[4:0] in the register form (imm_form_i=0) and by rb_idx_i in the immediate form. ra & mask is compared unsigned with zero, giving EQ if zero and GT otherwise. The branch tests EQ, and sel_i and signed_i are ignored.
- R6: In the bit-test family with clear_i=1, the mask is inverted and ra & mask is written back to ra_idx_i. With clear_i=0, ra_we_o stays 0.
- R7: In the compare family with imm_form_i=1, the second operand is rb_idx_i zero-extended to 32 bits, and rb_val_i has no effect.
- R8: A register index is legal when bit <index> of 32'hF000_27FF is set. If ra_idx_i is illegal, or rb_idx_i is illegal while imm_form_i=0, then illegal_o=1, every write enable is 0, taken_o=0 and next_pc_o = cia_i + 4.
- R9: Each result appears on the outputs one clock after issue_i is sampled, with done_o=1 for that one cycle. Without an issue, done_o and all write enables and taken_o are 0.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation valid this cycle |
| bit_test_i | input | 1 | 1 selects the bit-test family, 0 the compare family |
| imm_form_i | input | 1 | 1 means the rb index field is used as an immediate |
| signed_i | input | 1 | Signed compare select |
| clear_i | input | 1 | Bit-test clearing variant |
| sel_i | input | 2 | Condition select: 0 LT, 1 GT, 2 EQ, 3 subtract-and-compare |
| pol_i | input | 1 | Required value of the selected condition bit |
| link_i | input | 1 | Write link address |
| ra_idx_i | input | 5 | Index of first register |
| rb_idx_i | input | 5 | Index of second register or immediate |
| ra_val_i | input | 32 | First register value |
| rb_val_i | input | 32 | Second register value |
| so_i | input | 1 | Summary overflow flag |
| disp_i | input | 24 | Signed byte displacement |
| cia_i | input | 32 | Current instruction address |
| done_o | output | 1 | Result valid |
| illegal_o | output | 1 | Illegal register index |
| cr0_we_o | output | 1 | Condition field write enable |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next instruction address |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | 32 | Link value |
| ra_we_o | output | 1 | Writeback enable for ra |
| ra_idx_o | output | 5 | Writeback register index |
| ra_wdata_o | output | 32 | Writeback data |

## Verification
Three writes can land in the same result cycle: the ra writeback from subtract-and-compare or bit clearing, the link write, and the condition-field update. The taken or not-taken decision lands there too. The bench issues subtract-and-compare and clearing operations with link_i set, and checks that all enables and all data fields in the single done cycle match a scoreboard model built from the requirements. It also checks that an illegal index in the same position clears every one of those writes together.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  typedef enum logic [1:0] {
    SEL_LT  = 2'd0,
    SEL_GT  = 2'd1,
    SEL_EQ  = 2'd2,
    SEL_DEC = 2'd3
  } cond_sel_e;

  localparam int unsigned CR_W    = 4;
  localparam int unsigned CR_LT_B = 3;
  localparam int unsigned CR_GT_B = 2;
  localparam int unsigned CR_EQ_B = 1;
  localparam int unsigned CR_SO_B = 0;

  // cr0 bit position for a condition select
  function automatic int unsigned cr_bit(input cond_sel_e s);
    case (s)
      SEL_LT:  cr_bit = CR_LT_B;
      SEL_GT:  cr_bit = CR_GT_B;
      default: cr_bit = CR_EQ_B;
    endcase
  endfunction
endpackage

// File: rtl/fcb_regcheck.sv
module fcb_regcheck #(
  parameter int unsigned IDX_W = 5,
  parameter logic [(2**IDX_W)-1:0] IMPL_MAP = 32'hF000_27FF
) (
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  input  logic             rb_is_imm_i,
  output logic             legal_o
);
  logic ra_ok, rb_ok;
  assign ra_ok   = IMPL_MAP[ra_idx_i];
  assign rb_ok   = rb_is_imm_i | IMPL_MAP[rb_idx_i];
  assign legal_o = ra_ok & rb_ok;
endmodule

// File: rtl/fcb_mask.sv
module fcb_mask #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned POS_W = $clog2(XLEN)
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             invert_i,
  output logic [XLEN-1:0]  mask_o
);
  logic [XLEN-1:0] one_hot;
  // position 0 is the MSB
  always_comb begin
    one_hot = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (pos_i == POS_W'(i)) one_hot[XLEN-1-i] = 1'b1;
    end
  end
  assign mask_o = invert_i ? ~one_hot : one_hot;
endmodule

// File: rtl/fcb_compare.sv
module fcb_compare #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            signed_i,
  output logic            lt_o,
  output logic            gt_o,
  output logic            eq_o
);
  logic slt, ult;
  assign slt  = $signed(a_i) < $signed(b_i);
  assign ult  = a_i < b_i;
  assign eq_o = (a_i == b_i);
  assign lt_o = signed_i ? slt : ult;
  assign gt_o = ~eq_o & ~lt_o;
endmodule

// File: rtl/fcb_unit.sv
module fcb_unit
  import fcb_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned DISP_W     = 24,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [(2**IDX_W)-1:0] IMPL_MAP = 32'hF000_27FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              bit_test_i,
  input  logic              imm_form_i,
  input  logic              signed_i,
  input  logic              clear_i,
  input  logic [1:0]        sel_i,
  input  logic              pol_i,
  input  logic              link_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic              so_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   cia_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic              cr0_we_o,
  output logic [CR_W-1:0]   cr0_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              lr_we_o,
  output logic [XLEN-1:0]   lr_o,
  output logic              ra_we_o,
  output logic [IDX_W-1:0]  ra_idx_o,
  output logic [XLEN-1:0]   ra_wdata_o
);
  localparam int unsigned POS_W = $clog2(XLEN);

  cond_sel_e       sel;
  logic            legal;
  logic [XLEN-1:0] rb_eff, mask, masked, diff;
  logic [XLEN-1:0] cmp_a, cmp_b;
  logic            cmp_signed;
  logic            lt, gt, eq;
  logic [CR_W-1:0] cr_n;
  cond_sel_e       test_sel;
  logic            take_n;
  logic [XLEN-1:0] seq_pc, tgt_pc;
  logic [POS_W-1:0] bit_pos;
  logic            wb_n;
  logic [XLEN-1:0] wdata_n;

  assign sel = cond_sel_e'(sel_i);

  fcb_regcheck #(.IDX_W(IDX_W), .IMPL_MAP(IMPL_MAP)) u_regcheck (
    .ra_idx_i    (ra_idx_i),
    .rb_idx_i    (rb_idx_i),
    .rb_is_imm_i (imm_form_i),
    .legal_o     (legal)
  );

  assign rb_eff  = imm_form_i ? XLEN'(rb_idx_i) : rb_val_i;
  assign bit_pos = imm_form_i ? POS_W'(rb_idx_i) : rb_val_i[POS_W-1:0];

  fcb_mask #(.XLEN(XLEN)) u_mask (
    .pos_i    (bit_pos),
    .invert_i (clear_i),
    .mask_o   (mask)
  );

  assign masked = ra_val_i & mask;
  assign diff   = ra_val_i - rb_eff;

  // operand selection per family
  always_comb begin
    if (bit_test_i) begin
      cmp_a      = masked;
      cmp_b      = '0;
      cmp_signed = 1'b0;
      test_sel   = SEL_EQ;
      wb_n       = clear_i;
      wdata_n    = masked;
    end else begin
      cmp_a      = ra_val_i;
      cmp_b      = rb_eff;
      cmp_signed = signed_i;
      test_sel   = (sel == SEL_DEC) ? SEL_EQ : sel;
      wb_n       = (sel == SEL_DEC);
      wdata_n    = diff;
    end
  end

  fcb_compare #(.XLEN(XLEN)) u_compare (
    .a_i      (cmp_a),
    .b_i      (cmp_b),
    .signed_i (cmp_signed),
    .lt_o     (lt),
    .gt_o     (gt),
    .eq_o     (eq)
  );

  always_comb begin
    cr_n          = '0;
    cr_n[CR_LT_B] = lt;
    cr_n[CR_GT_B] = gt;
    cr_n[CR_EQ_B] = eq;
    cr_n[CR_SO_B] = so_i;
  end

  assign take_n = legal & (cr_n[cr_bit(test_sel)] == pol_i);
  assign seq_pc = cia_i + XLEN'(INSN_BYTES);
  assign tgt_pc = cia_i + {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      illegal_o  <= 1'b0;
      cr0_we_o   <= 1'b0;
      cr0_o      <= '0;
      taken_o    <= 1'b0;
      next_pc_o  <= '0;
      lr_we_o    <= 1'b0;
      lr_o       <= '0;
      ra_we_o    <= 1'b0;
      ra_idx_o   <= '0;
      ra_wdata_o <= '0;
    end else begin
      done_o     <= issue_i;
      illegal_o  <= issue_i & ~legal;
      cr0_we_o   <= issue_i & legal;
      taken_o    <= issue_i & take_n;
      lr_we_o    <= issue_i & legal & link_i;
      ra_we_o    <= issue_i & legal & wb_n;
      if (issue_i) begin
        cr0_o      <= cr_n;
        next_pc_o  <= take_n ? tgt_pc : seq_pc;
        lr_o       <= seq_pc;
        ra_idx_o   <= ra_idx_i;
        ra_wdata_o <= wdata_n;
      end
    end
  end

  p_done_follows_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> done_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(cr0_we_o || lr_we_o || ra_we_o || taken_o || illegal_o));
  p_illegal_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(cr0_we_o || lr_we_o || ra_we_o || taken_o));
  p_link_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && link_i) |=> (lr_o == $past(cia_i) + XLEN'(INSN_BYTES)));
  p_seq_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (taken_o || next_pc_o == $past(cia_i) + XLEN'(INSN_BYTES)));
  p_so_copied_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (cr0_o[CR_SO_B] == $past(so_i)));
  p_one_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_we_o |-> $onehot(cr0_o[CR_LT_B:CR_EQ_B]));
endmodule

// File: tb/fcb_unit_bench.sv
module fcb_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 0, bit_test_i = 0, imm_form_i = 0, signed_i = 0, clear_i = 0;
  logic [1:0]  sel_i = 0;
  logic        pol_i = 0, link_i = 0, so_i = 0;
  logic [4:0]  ra_idx_i = 0, rb_idx_i = 0;
  logic [31:0] ra_val_i = 0, rb_val_i = 0, cia_i = 0;
  logic [23:0] disp_i = 0;
  logic        done_o, illegal_o, cr0_we_o, taken_o, lr_we_o, ra_we_o;
  logic [3:0]  cr0_o;
  logic [31:0] next_pc_o, lr_o, ra_wdata_o;
  logic [4:0]  ra_idx_o;

  typedef struct packed {
    logic        done, illegal, cr0_we, taken, lr_we, ra_we;
    logic [3:0]  cr0;
    logic [31:0] next_pc, lr, ra_wdata;
    logic [4:0]  ra_idx;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done_run = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fcb_unit u_fcb_unit (
    .clk_i, .rst_ni, .issue_i, .bit_test_i, .imm_form_i, .signed_i, .clear_i,
    .sel_i, .pol_i, .link_i, .ra_idx_i, .rb_idx_i, .ra_val_i, .rb_val_i,
    .so_i, .disp_i, .cia_i, .done_o, .illegal_o, .cr0_we_o, .cr0_o, .taken_o,
    .next_pc_o, .lr_we_o, .lr_o, .ra_we_o, .ra_idx_o, .ra_wdata_o
  );

  function automatic bit impl(input logic [4:0] i);
    return (i <= 5'd10) || (i == 5'd13) || (i >= 5'd28);
  endfunction

  // reference model from the requirements
  function automatic exp_t model(input bit iss, input bit bt, input bit imm,
      input bit sg, input bit clr, input logic [1:0] sel, input bit pol,
      input bit lnk, input logic [4:0] ra_ix, input logic [4:0] rb_ix,
      input logic [31:0] ra, input logic [31:0] rb, input bit so,
      input logic [23:0] disp, input logic [31:0] cia);
    exp_t e;
    logic [31:0] b, m, a;
    bit lt, gt, eq, legal, t;
    int pick;
    e = '0;
    if (!iss) return e;
    e.done = 1;
    legal = impl(ra_ix) && (imm || impl(rb_ix));
    e.next_pc = cia + 32'd4;
    if (!legal) begin e.illegal = 1; return e; end
    e.ra_idx = ra_ix;
    e.lr = cia + 32'd4;
    e.lr_we = lnk;
    e.cr0_we = 1;
    b = imm ? {27'd0, rb_ix} : rb;
    if (bt) begin
      m = 32'h8000_0000 >> (imm ? rb_ix : rb[4:0]);
      if (clr) m = ~m;
      a = ra & m;
      eq = (a == 0); gt = !eq; lt = 0;
      pick = 2;
      e.ra_we = clr; e.ra_wdata = a;
    end else begin
      eq = (ra == b);
      lt = sg ? ($signed(ra) < $signed(b)) : (ra < b);
      gt = !eq && !lt;
      pick = (sel == 2'd3) ? 2 : int'(sel);
      e.ra_we = (sel == 2'd3); e.ra_wdata = ra - b;
    end
    e.cr0 = {lt, gt, eq, so};
    t = (pick == 0) ? lt : (pick == 1) ? gt : eq;
    e.taken = (t == pol);
    if (e.taken) e.next_pc = cia + {{8{disp[23]}}, disp};
    if (!e.ra_we) e.ra_wdata = 'x;
    if (!e.lr_we) e.lr = 'x;
    return e;
  endfunction

  task automatic drive(input string tag, input bit iss, input bit bt, input bit imm,
      input bit sg, input bit clr, input logic [1:0] sel, input bit pol,
      input bit lnk, input logic [4:0] ra_ix, input logic [4:0] rb_ix,
      input logic [31:0] ra, input logic [31:0] rb, input bit so,
      input logic [23:0] disp, input logic [31:0] cia);
    @(negedge clk_i);
    issue_i = iss; bit_test_i = bt; imm_form_i = imm; signed_i = sg; clear_i = clr;
    sel_i = sel; pol_i = pol; link_i = lnk; ra_idx_i = ra_ix; rb_idx_i = rb_ix;
    ra_val_i = ra; rb_val_i = rb; so_i = so; disp_i = disp; cia_i = cia;
    exp_q.push_back(model(iss, bt, imm, sg, clr, sel, pol, lnk, ra_ix, rb_ix,
                          ra, rb, so, disp, cia));
    tag_q.push_back(tag);
  endtask

  // monitor: compare one quarter period after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e, g;
        string tg;
        bit bad;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        g  = '{done_o, illegal_o, cr0_we_o, taken_o, lr_we_o, ra_we_o, cr0_o,
               next_pc_o, lr_o, ra_wdata_o, ra_idx_o};
        bad = (g.done != e.done) || (g.illegal != e.illegal) || (g.cr0_we != e.cr0_we) ||
              (g.taken != e.taken) || (g.lr_we != e.lr_we) || (g.ra_we != e.ra_we);
        if (e.done) bad |= (g.next_pc != e.next_pc);
        if (e.cr0_we) bad |= (g.cr0 != e.cr0);
        if (e.lr_we) bad |= (g.lr != e.lr);
        if (e.ra_we) bad |= (g.ra_wdata != e.ra_wdata) || (g.ra_idx != e.ra_idx);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: actual done=%b ill=%b crwe=%b cr=%h tk=%b pc=%h lrwe=%b lr=%h rawe=%b ra%0d=%h expected done=%b ill=%b crwe=%b cr=%h tk=%b pc=%h lrwe=%b lr=%h rawe=%b ra%0d=%h",
            tg, g.done, g.illegal, g.cr0_we, g.cr0, g.taken, g.next_pc, g.lr_we, g.lr,
            g.ra_we, g.ra_idx, g.ra_wdata, e.done, e.illegal, e.cr0_we, e.cr0, e.taken,
            e.next_pc, e.lr_we, e.lr, e.ra_we, e.ra_idx, e.ra_wdata);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog: actual run unfinished, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: outputs held at zero in reset
    repeat (2) @(negedge clk_i);
    checks++;
    if ({done_o, illegal_o, cr0_we_o, cr0_o, taken_o, next_pc_o, lr_we_o, lr_o,
         ra_we_o, ra_idx_o, ra_wdata_o} != '0) begin
      fails++;
      $display("FAIL R10: actual nonzero outputs in reset, expected all zero");
    end
    rst_ni = 1'b1;
    //     tag   iss bt imm sg clr sel pol lnk ra rb  ra_val        rb_val        so disp        cia
    drive("R1 signed lt", 1,0,0,1,0,2'd0,1,0, 3, 4, 32'hFFFF_FFFB, 32'd3,        0, 24'h000040, 32'h1000);
    drive("R1 unsigned gt",1,0,0,0,0,2'd0,1,0, 3, 4, 32'hFFFF_FFFB, 32'd3,        1, 24'h000040, 32'h1004);
    drive("R2 gt pol0",   1,0,0,1,0,2'd1,0,0, 1, 2, 32'd9,         32'd2,        0, 24'h000100, 32'h2000);
    drive("R4 eq link",   1,0,0,0,0,2'd2,1,1, 5, 6, 32'h1234,      32'h1234,     1, 24'hFFFFF0, 32'h3000);
    drive("R7 imm eq",    1,0,1,0,0,2'd2,1,0, 7, 20,32'd20,        32'hDEAD_BEEF,0, 24'h000008, 32'h3100);
    drive("R7 imm lt",    1,0,1,1,0,2'd0,1,0, 7, 31,32'hFFFF_FFFF, 32'd0,        0, 24'h000008, 32'h3200);
    drive("R3 dec eq",    1,0,0,1,0,2'd3,1,0, 8, 9, 32'd10,        32'd10,       0, 24'h000020, 32'h4000);
    drive("R3 dec link",  1,0,0,1,0,2'd3,1,1, 8, 9, 32'd7,         32'd3,        0, 24'h000020, 32'h4010);
    drive("R5 reg bit",   1,1,0,1,0,2'd0,1,0, 2, 3, 32'h4000_0000, 32'd33,       0, 24'h000010, 32'h5000);
    drive("R5 imm bit",   1,1,1,0,0,2'd0,1,1, 2, 31,32'hFFFF_FFFE, 32'd0,        1, 24'h000010, 32'h5010);
    drive("R6 clear reg", 1,1,0,0,1,2'd1,0,1, 10,13,32'h8000_0001, 32'd0,        0, 24'hFFFF00, 32'h6000);
    drive("R6 clear imm", 1,1,1,0,1,2'd2,1,0, 30,5, 32'h0400_0000, 32'd0,        0, 24'h000004, 32'h6010);
    drive("R8 bad ra",    1,0,0,1,0,2'd3,1,1, 11,1, 32'd5,         32'd5,        0, 24'h000004, 32'h7000);
    drive("R8 bad rb",    1,1,0,0,1,2'd2,1,1, 1, 20,32'd0,         32'd0,        0, 24'h000004, 32'h7010);
    drive("R9 idle",      0,0,0,1,0,2'd3,1,1, 1, 2, 32'd5,         32'd5,        0, 24'h000004, 32'h7020);
    drive("R9 back2back", 1,0,0,0,0,2'd1,1,0, 28,29,32'd1,         32'd2,        0, 24'h000004, 32'h7030);
    drive("R2 not taken", 1,0,0,0,0,2'd2,1,1, 28,29,32'd1,         32'd2,        0, 24'h000004, 32'h7034);
    drive("R9 idle end",  0,0,0,0,0,2'd0,0,0, 0, 0, 32'd0,         32'd0,        0, 24'h000000, 32'h0);
    repeat (3) @(negedge clk_i);
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule